// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and main memory and absorbs processor stores, so that the processor keeps running while memory writes complete in the background. It holds a small number of entries. Each entry covers one aligned memory block of several words and keeps one valid bit for every byte of that block. Each incoming store is compared with every held entry. When it falls in a block that an entry already covers, its bytes are folded into that entry. Otherwise it takes a free entry. A run of stores to neighbouring words therefore leaves the block as a single wide write with a byte-enable mask, and not as many narrow writes.

Entries leave in arrival order. The oldest entry moves into a one-entry drain register, and that register presents the block to memory until memory accepts it. When an entry moves into the drain register it leaves the merge pool. A store to the same block that arrives in that cycle or later opens a new entry. Loads look up the buffer without waiting for the drain. For every byte of the requested word, the newest buffered copy wins. The block reports which bytes it could not supply, and only those bytes are taken from the memory data that the load path provides.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset, `st_ready` is 1, `mem_wr_valid` is 0 and no byte is held, so any load returns `ld_mem_be` = all ones.
- R2: A store is merged into a held entry of the same block when that entry is not starting to drain in the same cycle. The merge ORs the byte mask and overwrites only the enabled bytes, and the block later leaves as one write.
- R3: A store with no mergeable entry takes a free entry. When all entries are occupied and none can merge, `st_ready` is 0 and the store waits. When all entries are occupied, a store that can merge is still accepted.
- R4: Entries reach memory oldest first, one write per entry. While `mem_wr_ready` is 0, `mem_wr_valid`, `mem_wr_addr`, `mem_wr_data` and `mem_wr_be` stay unchanged.
- R5: A store to the block of the entry that starts draining in the same cycle goes into a new entry, and that block produces two separate writes.
- R6: The load lookup uses the byte priority: newest merge entry, then the drain register, then `ld_mem_data`. `ld_mem_be` bit j is 1 exactly when byte j came from `ld_mem_data`.
- R7: Encoding: the block address is `addr[31:4]`, and `mem_wr_addr` carries it with bits [3:0] equal to zero. Word index w is `addr[3:2]`. Store byte-enable bit j maps to block byte 4w+j. Block byte i is `mem_wr_be[i]` and `mem_wr_data[8i+7:8i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | 32 | Store byte address, word aligned |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Store byte enables |
| ld_addr | input | 32 | Load byte address, word aligned |
| ld_mem_data | input | 32 | Memory copy of the loaded word |
| ld_data | output | 32 | Load result with buffered bytes applied |
| ld_mem_be | output | 4 | Bytes of the load taken from memory |
| mem_wr_valid | output | 1 | Block write presented |
| mem_wr_ready | input | 1 | Memory takes the block write |
| mem_wr_addr | output | 32 | Block-aligned write address |
| mem_wr_data | output | 128 | Block write data |
| mem_wr_be | output | 16 | Block byte enables |

## Verification
The assertions take for granted that every offered store has at least one byte enable set, and that a store offered while `st_ready` is 0 keeps its payload until it is taken. Without the first, an entry could drain with an empty mask. The stimulus meets both conditions: every store has a non-zero `st_be`, and the driver holds `st_valid` and the payload steady until acceptance. `mem_wr_ready` may be held low for long stretches. The bench uses this to fill the buffer, to hit the stall, and to observe the held drain request.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned SWB_ADDR_W  = 32;
  localparam int unsigned SWB_WORD_W  = 32;
  localparam int unsigned SWB_WORDS   = 4;
  localparam int unsigned SWB_ENTRIES = 4;
endpackage

// File: rtl/swb_match.sv
module swb_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned TW = 28
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][TW-1:0] tags,
  input  logic [TW-1:0]        key,
  output logic [N-1:0]         hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/swb_lane_expand.sv
module swb_lane_expand #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned BPW    = WORD_W / 8,
  localparam int unsigned NBYTES = WORDS * BPW,
  localparam int unsigned WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [WSEL_W-1:0]     wsel,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [BPW-1:0]        wbe,
  output logic [NBYTES*8-1:0]   bdat,
  output logic [NBYTES-1:0]     bmsk,
  output logic [NBYTES*8-1:0]   bbit
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < BPW; b++) begin : g_byte
      localparam int unsigned IDX = w * BPW + b;
      assign bmsk[IDX]          = (wsel == WSEL_W'(w)) && wbe[b];
      assign bdat[IDX*8 +: 8]   = wdata[b*8 +: 8];
      assign bbit[IDX*8 +: 8]   = {8{bmsk[IDX]}};
    end
  end
endmodule

// File: rtl/swb_load_bypass.sv
module swb_load_bypass #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BPW = WORD_W / 8
) (
  input  logic              ent_hit,
  input  logic [WORD_W-1:0] ent_word,
  input  logic [BPW-1:0]    ent_be,
  input  logic              out_hit,
  input  logic [WORD_W-1:0] out_word,
  input  logic [BPW-1:0]    out_be,
  input  logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] data,
  output logic [BPW-1:0]    mem_be
);
  for (genvar b = 0; b < BPW; b++) begin : g_byte
    logic from_ent, from_out;
    assign from_ent = ent_hit && ent_be[b];
    assign from_out = out_hit && out_be[b];
    assign data[b*8 +: 8] = from_ent ? ent_word[b*8 +: 8] :
                            from_out ? out_word[b*8 +: 8] : mem_word[b*8 +: 8];
    assign mem_be[b] = !(from_ent || from_out);
  end
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W  = SWB_ADDR_W,
  parameter int unsigned WORD_W  = SWB_WORD_W,
  parameter int unsigned WORDS   = SWB_WORDS,
  parameter int unsigned ENTRIES = SWB_ENTRIES,
  localparam int unsigned BPW      = WORD_W / 8,
  localparam int unsigned NBYTES   = WORDS * BPW,
  localparam int unsigned BLK_W    = NBYTES * 8,
  localparam int unsigned OFF_W    = $clog2(NBYTES),
  localparam int unsigned LANE_OFF = $clog2(BPW),
  localparam int unsigned WSEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned BA_W     = ADDR_W - OFF_W,
  localparam int unsigned IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [WORD_W-1:0] st_data,
  input  logic [BPW-1:0]    st_be,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_mem_data,
  output logic [WORD_W-1:0] ld_data,
  output logic [BPW-1:0]    ld_mem_be,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [BLK_W-1:0]  mem_wr_data,
  output logic [NBYTES-1:0] mem_wr_be
);
  // entry state
  logic [ENTRIES-1:0]             vld_q, vld_n;
  logic [ENTRIES-1:0][BA_W-1:0]   tag_q;
  logic [ENTRIES-1:0][BLK_W-1:0]  dat_q, dat_n;
  logic [ENTRIES-1:0][NBYTES-1:0] msk_q, msk_n;
  logic [ENTRIES-1:0]             ent_we;
  logic [IDX_W-1:0]               head_q, head_n, tail_q, tail_n;
  // drain register
  logic                           ov_q, ov_n;
  logic [BA_W-1:0]                otag_q;
  logic [BLK_W-1:0]               odat_q;
  logic [NBYTES-1:0]              omsk_q;

  logic                           unused_lane_bits;
  assign unused_lane_bits = ^{st_addr[LANE_OFF-1:0], ld_addr[LANE_OFF-1:0]};

  // store side: lane expansion and block match
  logic [BA_W-1:0]    st_tag;
  logic [WSEL_W-1:0]  st_wsel;
  logic [BLK_W-1:0]   st_bdat, st_bbit;
  logic [NBYTES-1:0]  st_bmsk;
  logic [ENTRIES-1:0] st_hit, launch_vec, merge_vec;
  logic               launch, merge_ok, full, do_merge, do_alloc;

  assign st_tag  = st_addr[ADDR_W-1:OFF_W];
  assign st_wsel = st_addr[OFF_W-1:LANE_OFF];

  swb_lane_expand #(.WORD_W(WORD_W), .WORDS(WORDS)) u_expand (
    .wsel(st_wsel), .wdata(st_data), .wbe(st_be),
    .bdat(st_bdat), .bmsk(st_bmsk), .bbit(st_bbit)
  );

  swb_match #(.N(ENTRIES), .TW(BA_W)) u_st_match (
    .vld(vld_q), .tags(tag_q), .key(st_tag), .hit(st_hit)
  );

  // the oldest entry moves to the drain register when that register is free
  assign launch     = vld_q[head_q] && (!ov_q || mem_wr_ready);
  assign launch_vec = launch ? (ENTRIES'(1) << head_q) : '0;
  assign merge_vec  = st_hit & ~launch_vec;
  assign merge_ok   = |merge_vec;
  assign full       = &vld_q;
  assign st_ready   = merge_ok || !full;
  assign do_merge   = st_valid && merge_ok;
  assign do_alloc   = st_valid && st_ready && !merge_ok;

  // R2 / R6: at most one held entry per block
  a_r2_one_store_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_hit) <= 1);
  // R3: allocation only lands on a free slot
  a_r3_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |-> !vld_q[tail_q]);
  // R4: whenever anything is held, the head slot is the oldest live one
  a_r4_head_live: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q != '0) |-> vld_q[head_q]);

  // control next state
  always_comb begin
    vld_n  = vld_q;
    head_n = head_q;
    tail_n = tail_q;
    ov_n   = ov_q;
    if (ov_q && mem_wr_ready) ov_n = 1'b0;
    if (launch) begin
      vld_n[head_q] = 1'b0;
      head_n        = (head_q == IDX_W'(ENTRIES-1)) ? '0 : head_q + 1'b1;
      ov_n          = 1'b1;
    end
    if (do_alloc) begin
      vld_n[tail_q] = 1'b1;
      tail_n        = (tail_q == IDX_W'(ENTRIES-1)) ? '0 : tail_q + 1'b1;
    end
  end

  // entry data next state and write enables
  always_comb begin
    for (int k = 0; k < ENTRIES; k++) begin
      ent_we[k] = (do_alloc && tail_q == IDX_W'(k)) || (do_merge && merge_vec[k]);
      if (merge_vec[k]) begin
        dat_n[k] = (dat_q[k] & ~st_bbit) | (st_bdat & st_bbit);
        msk_n[k] = msk_q[k] | st_bmsk;
      end else begin
        dat_n[k] = st_bdat;
        msk_n[k] = st_bmsk;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      head_q <= head_n;
      tail_q <= tail_n;
      ov_q   <= ov_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < ENTRIES; k++) begin
      if (ent_we[k]) begin
        tag_q[k] <= st_tag;
        dat_q[k] <= dat_n[k];
        msk_q[k] <= msk_n[k];
      end
    end
    if (launch) begin
      otag_q <= tag_q[head_q];
      odat_q <= dat_q[head_q];
      omsk_q <= msk_q[head_q];
    end
  end

  assign mem_wr_valid = ov_q;
  assign mem_wr_addr  = {otag_q, {OFF_W{1'b0}}};
  assign mem_wr_data  = odat_q;
  assign mem_wr_be    = omsk_q;

  // R4: a presented write holds until taken
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)
      && $stable(mem_wr_data) && $stable(mem_wr_be)));
  // R4: a drained block always carries at least one byte
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_be != '0));

  // load side
  logic [BA_W-1:0]    ld_tag;
  logic [WSEL_W-1:0]  ld_wsel;
  logic [ENTRIES-1:0] ld_hit;
  logic [WORD_W-1:0]  ent_word;
  logic [BPW-1:0]     ent_be;
  logic               out_hit;

  assign ld_tag  = ld_addr[ADDR_W-1:OFF_W];
  assign ld_wsel = ld_addr[OFF_W-1:LANE_OFF];

  swb_match #(.N(ENTRIES), .TW(BA_W)) u_ld_match (
    .vld(vld_q), .tags(tag_q), .key(ld_tag), .hit(ld_hit)
  );

  // R6: lookup never sees two entries for one block
  a_r6_one_load_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ld_hit) <= 1);

  always_comb begin
    ent_word = '0;
    ent_be   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (ld_hit[k]) begin
        ent_word = dat_q[k][int'(ld_wsel)*WORD_W +: WORD_W];
        ent_be   = msk_q[k][int'(ld_wsel)*BPW +: BPW];
      end
    end
  end

  assign out_hit = ov_q && (otag_q == ld_tag);

  swb_load_bypass #(.WORD_W(WORD_W)) u_bypass (
    .ent_hit(|ld_hit), .ent_word(ent_word), .ent_be(ent_be),
    .out_hit(out_hit),
    .out_word(odat_q[int'(ld_wsel)*WORD_W +: WORD_W]),
    .out_be(omsk_q[int'(ld_wsel)*BPW +: BPW]),
    .mem_word(ld_mem_data), .data(ld_data), .mem_be(ld_mem_be)
  );
endmodule

// File: tb/tb_store_merge_buffer.sv
module tb_store_merge_buffer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid;
  logic         st_ready;
  logic [31:0]  st_addr, st_data;
  logic [3:0]   st_be;
  logic [31:0]  ld_addr, ld_mem_data, ld_data;
  logic [3:0]   ld_mem_be;
  logic         mem_wr_valid, mem_wr_ready;
  logic [31:0]  mem_wr_addr;
  logic [127:0] mem_wr_data;
  logic [15:0]  mem_wr_be;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0]  a;
    logic [127:0] d;
    logic [15:0]  m;
  } exp_t;
  exp_t exp_q[$];

  store_merge_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .ld_addr(ld_addr), .ld_mem_data(ld_mem_data), .ld_data(ld_data),
    .ld_mem_be(ld_mem_be),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_exp(input logic [31:0] a, input logic [127:0] d,
                          input logic [15:0] m);
    exp_t e;
    e.a = a; e.d = d; e.m = m;
    exp_q.push_back(e);
  endtask

  // monitor: compare each accepted drain write with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {96'b0, mem_wr_addr}, 128'b0);
      end else begin
        exp_t e;
        logic [127:0] bm;
        e = exp_q.pop_front();
        for (int i = 0; i < 16; i++) bm[i*8 +: 8] = {8{e.m[i]}};
        chk(mem_wr_addr == e.a, "R4/R7 drain address", {96'b0, mem_wr_addr}, {96'b0, e.a});
        chk(mem_wr_be == e.m, "R2/R4 drain byte enables", {112'b0, mem_wr_be}, {112'b0, e.m});
        chk((mem_wr_data & bm) == (e.d & bm), "R2/R7 drain data",
            mem_wr_data & bm, e.d & bm);
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
      $finish;
    end
  end

  // driver: inputs change just after a rising edge
  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [31:0] expd,
                         input logic [3:0] expm, input string req);
    ld_addr = a; ld_mem_data = 32'hEEEE_EEEE;
    @(negedge clk);
    chk(ld_data == expd, req, {96'b0, ld_data}, {96'b0, expd});
    chk(ld_mem_be == expm, req, {124'b0, ld_mem_be}, {124'b0, expm});
    @(posedge clk); #1;
  endtask

  task automatic drain_all;
    mem_wr_ready = 1'b1;
    for (int i = 0; i < 40 && (exp_q.size() != 0 || mem_wr_valid); i++) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R4 all expected writes drained", 128'(exp_q.size()), 128'b0);
  endtask

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    ld_addr = 32'h100; ld_mem_data = 32'hEEEE_EEEE; mem_wr_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(st_ready == 1'b1, "R1 st_ready after reset", {127'b0, st_ready}, 128'd1);
    chk(mem_wr_valid == 1'b0, "R1 no write after reset", {127'b0, mem_wr_valid}, 128'd0);
    chk(ld_mem_be == 4'hF, "R1 nothing held after reset", {124'b0, ld_mem_be}, 128'hF);
    @(posedge clk); #1;

    // scenario A: memory blocked, fill, merge, stall, bypass
    push_exp(32'h100, {96'b0, 32'h1111_1111}, 16'h000F);
    push_exp(32'h100, {32'h4444_4444, 32'h0, 32'h3333_3333, 32'h2222_2222}, 16'h8035);
    push_exp(32'h200, {32'h0, 32'h0, 32'h9999_9999, 32'h5555_5555}, 16'h00FF);
    push_exp(32'h300, {32'h0, 32'h6666_6666, 64'h0}, 16'h0600);
    push_exp(32'h400, {32'h7777_7777, 96'h0}, 16'hF000);
    do_store(32'h100, 32'h1111_1111, 4'hF);
    do_store(32'h100, 32'h2222_2222, 4'b0101); // R5: same cycle as drain start
    do_store(32'h104, 32'h3333_3333, 4'b0011); // R2 merge
    do_store(32'h10C, 32'h4444_4444, 4'b1000); // R2 merge
    do_store(32'h200, 32'h5555_5555, 4'hF);
    do_store(32'h308, 32'h6666_6666, 4'b0110);
    do_store(32'h40C, 32'h7777_7777, 4'hF);     // wraps, buffer now full
    // R3 stall: full, no mergeable block
    st_valid = 1'b1; st_addr = 32'h500; st_data = 32'h5A5A_5A5A; st_be = 4'hF;
    @(negedge clk);
    chk(st_ready == 1'b0, "R3 stall when full", {127'b0, st_ready}, 128'd0);
    @(negedge clk);
    chk(st_ready == 1'b0, "R3 stall persists", {127'b0, st_ready}, 128'd0);
    // R4 held request while memory is not ready
    chk(mem_wr_valid && mem_wr_addr == 32'h100 && mem_wr_be == 16'h000F,
        "R4 request held while blocked", {96'b0, mem_wr_addr}, 128'h100);
    @(posedge clk); #1;
    st_valid = 1'b0;
    // R3 merge accepted while full
    st_valid = 1'b1; st_addr = 32'h204; st_data = 32'h9999_9999; st_be = 4'hF;
    @(negedge clk);
    chk(st_ready == 1'b1, "R3 merge accepted while full", {127'b0, st_ready}, 128'd1);
    @(posedge clk); #1;
    st_valid = 1'b0;
    // R6 load bypass, byte priority
    do_load(32'h100, 32'h1122_1122, 4'b0000, "R6 entry over drain register");
    do_load(32'h104, 32'hEEEE_3333, 4'b1100, "R6 partial word from memory");
    do_load(32'h308, 32'hEE66_66EE, 4'b1001, "R6 middle bytes buffered");
    do_load(32'h10C, 32'h44EE_EEEE, 4'b0111, "R6 top byte buffered");
    do_load(32'h204, 32'h9999_9999, 4'b0000, "R6 merged word");
    do_load(32'h500, 32'hEEEE_EEEE, 4'b1111, "R6 stalled store not visible");
    chk(mem_wr_valid && mem_wr_addr == 32'h100, "R4 still held after wait",
        {96'b0, mem_wr_addr}, 128'h100);
    drain_all();
    do_load(32'h100, 32'hEEEE_EEEE, 4'b1111, "R6 nothing held after drain");

    // scenario B: memory ready, back-to-back stores split by drain start (R5)
    push_exp(32'h900, {96'b0, 32'h1234_5678}, 16'h000F);
    push_exp(32'h900, {64'b0, 32'h9ABC_DEF0, 32'h0}, 16'h00F0);
    mem_wr_ready = 1'b1;
    do_store(32'h900, 32'h1234_5678, 4'hF);
    do_store(32'h904, 32'h9ABC_DEF0, 4'hF);
    drain_all();

    // scenario C: overwrite of already held bytes (R2)
    mem_wr_ready = 1'b0;
    push_exp(32'h700, {64'b0, 32'h7070_7070, 32'h0}, 16'h00F0);
    push_exp(32'h800, {96'b0, 32'hA0A0_BBBB}, 16'h000F);
    do_store(32'h704, 32'h7070_7070, 4'hF);
    do_store(32'h800, 32'hA0A0_A0A0, 4'hF);
    do_store(32'h800, 32'h0000_BBBB, 4'b0011);
    do_load(32'h800, 32'hA0A0_BBBB, 4'b0000, "R2 overwrite merged bytes");
    drain_all();

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule